// File: doc/BRIEF.md
# Periodic Schedule Cycle Generator

This block issues the cycle-start pulses that launch a gate-list sequencer on one switch port. Software programs an absolute start time (64 bits, nanoseconds) as two 32-bit halves and a period counted in reference-clock cycles. The period is the nanosecond cycle time converted to clocks with rounding up, and it fits in 32 bits. The block watches a free-running 64-bit nanosecond time counter, which arrives as an input. When that counter reaches the start time, the block emits one pulse, and after that one pulse every period.

The period register also acts as the arm control. Writing a nonzero period while the block is idle arms it. In the same clock it latches the staged 64-bit start time and the period, so a half-written start time can never cause a pulse. Writing zero stops the block. Software has to write zero before it can reprogram the block, and there is one instance per port.

Top module: `cycle_pulse_gen`

## Requirements
- R1: After reset `armed` and `cyclePulse` are low, and they stay low until the block is armed.
- R2: A write selects its target with `wrSel`: 0 writes the staged compare high half, 1 writes the staged compare low half, 2 writes the period, and 3 has no effect. A period write with nonzero data while disarmed raises `armed` in the next cycle and latches `{high,low}` and the period.
- R3: Once armed, the first pulse appears one cycle after the first rising edge at which `timeNs` is greater than or equal to the latched 64-bit compare value.
- R4: After any pulse, the next pulse comes exactly `period` clock cycles later, for as long as the block stays armed.
- R5: A period write of zero lowers `armed` in the next cycle, and no pulse appears from that cycle on.
- R6: A compare write made while armed does not change the pending start time or the running cycle. It takes effect only at the next arming.
- R7: A nonzero period write made while armed is ignored, and the pulse spacing keeps its old value.
- R8: If the start time is already in the past at arming, the first pulse appears two cycles after the arming write edge.
- R9: A period of 1 gives a pulse on every cycle.
- R10: The start comparison uses all 64 bits, so a nonzero high half holds off the pulse until `timeNs` passes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timeNs | input | 64 | Free-running nanosecond time counter |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 high, 1 low, 2 period) |
| wrData | input | 32 | Register write data |
| armed | output | 1 | Generator armed (waiting or running) |
| cyclePulse | output | 1 | One-cycle cycle-start pulse |

## Verification
A wrong latched compare value shows up as a first pulse that is early or late compared with the time counter. This is seen in the first cycle the model expects a pulse, or the first cycle it expects none. A countdown that is off by one, or a period that was wrongly overwritten, moves the second pulse, so spacing errors show within one period of the first pulse. A state machine that ignores disarm or re-arms on its own shows on `armed` one cycle after the write. The bench therefore compares both outputs with its model on every clock, across arming and disarming, past start times, period 1, and a start time that crosses the 32-bit boundary.

// File: rtl/cycle_pulse_pkg.sv
package cycle_pulse_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CMP_HI = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CMP_LO = 2'd1;
  localparam logic [SEL_W-1:0] SEL_LEN    = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } genState_t;

  typedef struct packed {
    logic capture;
    logic fire;
    logic tick;
    logic clear;
  } genStrobes_t;

  typedef struct packed {
    logic reached;
    logic cntDone;
  } genStatus_t;
endpackage

// File: rtl/cycle_pulse_dp.sv
module cycle_pulse_dp
  import cycle_pulse_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int LEN_W = 32,
  localparam int TIME_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] timeNs,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [REG_W-1:0]  wrData,
  input  genStrobes_t       strobes,
  output genStatus_t        status,
  output logic              pulse
);
  logic [REG_W-1:0]  cmpHiQ, cmpLoQ;
  logic [TIME_W-1:0] activeCmpQ;
  logic [LEN_W-1:0]  periodQ, cntQ;
  logic              pulseQ;

  // staged compare halves, writable at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpHiQ <= '0;
      cmpLoQ <= '0;
    end else if (wrEn) begin
      if (wrSel == SEL_CMP_HI) cmpHiQ <= wrData;
      if (wrSel == SEL_CMP_LO) cmpLoQ <= wrData;
    end
  end

  // atomic capture of compare and period at arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeCmpQ <= '0;
      periodQ    <= '0;
    end else if (strobes.capture) begin
      activeCmpQ <= {cmpHiQ, cmpLoQ};
      periodQ    <= wrData[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ   <= '0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strobes.fire;
      if (strobes.fire)      cntQ <= periodQ - LEN_W'(1);
      else if (strobes.tick) cntQ <= cntQ - LEN_W'(1);
    end
  end

  assign status.reached = (timeNs >= activeCmpQ);
  assign status.cntDone = (cntQ == '0);
  assign pulse          = pulseQ;

  // R6: the live compare only changes on an arming capture
  a_r6_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> $stable(activeCmpQ));
  // R7: the live period only changes on an arming capture
  a_r7_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> $stable(periodQ));
  // R4: with a period above one, a pulse is never followed directly by another
  a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseQ && periodQ > LEN_W'(1) && !strobes.capture) |=> !pulseQ);
endmodule

// File: rtl/cycle_pulse_ctrl.sv
module cycle_pulse_ctrl
  import cycle_pulse_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [REG_W-1:0] wrData,
  input  genStatus_t       status,
  output genStrobes_t      strobes,
  output logic             armed
);
  genState_t stateQ, stateD;
  logic lenWr, armWr, disWr;

  assign lenWr = wrEn && (wrSel == SEL_LEN);
  assign armWr = lenWr && (wrData != '0);
  assign disWr = lenWr && (wrData == '0);

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    if (disWr) begin
      strobes.clear = 1'b1;
      stateD        = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (armWr) begin
          strobes.capture = 1'b1;
          stateD          = ST_WAIT;
        end
        ST_WAIT: if (status.reached) begin
          strobes.fire = 1'b1;
          stateD       = ST_RUN;
        end
        ST_RUN: begin
          if (status.cntDone) strobes.fire = 1'b1;
          else                strobes.tick = 1'b1;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign armed = (stateQ != ST_IDLE);

  // R5: a zero period write always returns to idle
  a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    disWr |=> stateQ == ST_IDLE);
  // R3: reaching the start time while waiting moves to running
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_WAIT && status.reached && !disWr) |=> stateQ == ST_RUN);
  // R2: arming from idle leads to waiting
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_IDLE && armWr) |=> stateQ == ST_WAIT);
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
endmodule

// File: rtl/cycle_pulse_gen.sv
module cycle_pulse_gen
  import cycle_pulse_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int LEN_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*REG_W-1:0] timeNs,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [REG_W-1:0]   wrData,
  output logic               armed,
  output logic               cyclePulse
);
  genStrobes_t strobes;
  genStatus_t  status;

  cycle_pulse_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .status(status), .strobes(strobes), .armed(armed)
  );

  cycle_pulse_dp #(.REG_W(REG_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .timeNs(timeNs), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .strobes(strobes), .status(status), .pulse(cyclePulse)
  );

  // R1: no pulse unless the block was armed in the previous cycle
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(armed) |-> !cyclePulse);
endmodule

// File: tb/cycle_pulse_gen_bench.sv
`timescale 1ns/1ps
module cycle_pulse_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] timeNs = 64'd0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [31:0] wrData = 32'd0;
  logic        armed, cyclePulse;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit comparing = 1'b0;
  string tag = "R1";

  // reference model state
  bit          mArmed = 0, mWait = 0, mPulse = 0;
  logic [31:0] mHi = 0, mLo = 0;
  logic [63:0] mCmp = 0;
  longint      mPer = 0, mLeft = 0;

  cycle_pulse_gen u_cycle_pulse_gen (
    .clk(clk), .rst_n(rst_n), .timeNs(timeNs), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .armed(armed), .cyclePulse(cyclePulse)
  );

  always #5 clk = ~clk;

  always @(negedge clk) #1 timeNs = timeNs + 64'd10;

  always @(posedge clk) begin
    if (!rst_n) begin
      mArmed = 0; mWait = 0; mPulse = 0; mHi = 0; mLo = 0; mCmp = 0;
      mPer = 0; mLeft = 0;
    end else begin
      bit nextPulse;
      nextPulse = 0;
      if (wrEn && wrSel == 2'd0) mHi = wrData;
      if (wrEn && wrSel == 2'd1) mLo = wrData;
      if (wrEn && wrSel == 2'd2 && wrData == 0) begin
        mArmed = 0; mWait = 0;
      end else if (!mArmed) begin
        if (wrEn && wrSel == 2'd2) begin
          mArmed = 1; mWait = 1; mCmp = {mHi, mLo}; mPer = longint'(wrData);
        end
      end else if (mWait) begin
        if (timeNs >= mCmp) begin
          nextPulse = 1; mWait = 0; mLeft = mPer;
        end
      end else begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          nextPulse = 1; mLeft = mPer;
        end
      end
      mPulse = nextPulse;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (comparing) begin
      checks++;
      if (cyclePulse !== mPulse || armed !== mArmed) begin
        fails++;
        $display("FAIL %s cycle %0d: pulse=%b armed=%b expected pulse=%b armed=%b",
                 tag, cycles, cyclePulse, armed, mPulse, mArmed);
      end
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired: cycles=%0d expected below 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    #2 wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    #2 wrEn = 1'b0; wrSel = 2'd3; wrData = 32'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setTime(input logic [63:0] v);
    @(negedge clk);
    #2 timeNs = v;
  endtask

  initial begin
    idle(3);
    #2 rst_n = 1'b1;
    @(negedge clk);
    #3;
    checks++;
    if (armed !== 1'b0 || cyclePulse !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: armed=%b pulse=%b expected 0 0", armed, cyclePulse);
    end
    comparing = 1'b1;
    tag = "R1"; idle(5);
    wr(2'd3, 32'h1234);
    idle(3);

    // future start, period 5
    tag = "R3";
    wr(2'd0, 32'd0);
    wr(2'd1, timeNs[31:0] + 32'd200);
    tag = "R2";
    wr(2'd2, 32'd5);
    tag = "R4"; idle(40);

    // compare writes and period rewrite while running
    tag = "R6";
    wr(2'd1, 32'd0);
    wr(2'd0, 32'hFFFF);
    idle(12);
    tag = "R7";
    wr(2'd2, 32'd3);
    idle(20);

    tag = "R5";
    wr(2'd2, 32'd0);
    idle(15);

    // past start, period 1
    tag = "R8";
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd1);
    tag = "R9"; idle(10);
    tag = "R5"; wr(2'd2, 32'd0);
    idle(4);

    // start time above the 32-bit boundary
    tag = "R10";
    setTime(64'h0000_0000_FFFF_FF00);
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd7);
    tag = "R6"; wr(2'd0, 32'd0);
    tag = "R10"; idle(60);
    tag = "R5"; wr(2'd2, 32'd0);
    idle(5);

    comparing = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule